// File: doc/BRIEF.md
# Machine interrupt pending/enable register pair

This block keeps the machine-level interrupt-pending and interrupt-enable registers of a hart, together with the two supervisor-level windows onto them. A control-register port presents an address, a write-data word and an operation code. The port returns the current contents of the addressed register. On the same clock edge it applies a full write, a bit-set or a bit-clear. Bit i of both registers stands for interrupt cause i. Bits 15:0 hold the standard causes and bits 16 and up are left for platform use; none of the platform bits is implemented here.

Several pending bits are driven by hardware:
- The machine external, timer and software pending bits mirror their request lines.
- The supervisor software pending bit can be raised by a platform controller strobe.
- The counter-overflow pending bit is raised whenever any overflow flag is high.

The supervisor external pending bit is special. Software holds its own copy of it, and a read shows that copy ORed with the external controller's line. Read-modify-write operations act on the software copy alone.

The supervisor windows show a bit only when the matching bit of the delegation input is set. Both current register values go out to the trap logic, which sits outside this block.

Top module: `irq_pend_en_regs`

## Requirements
- R1: Pending bit 3 follows `m_sw_irq`, bit 7 follows `m_tmr_irq` and bit 11 follows `m_ext_irq`. Writes to the pending register never change these bits.
- R2: In the pending register only bits 1, 5, 9 and 13 are software-writable. A write of 0, or a clear operation with the bit set in the operand, drops that pending bit at the next edge unless hardware raises it again. All other bits read as the hardware lines, or as zero.
- R3: In the enable register bits 1, 3, 5, 7, 9, 11 and 13 are writable. Every other enable bit reads as zero whatever is written.
- R4: A read of pending bit 9 returns the software-held bit ORed with `s_ext_ctrl`.
- R5: A write operation loads the software copy of bit 9 from write-data bit 9. Set and clear operations modify it from the operand bit alone. `s_ext_ctrl` never enters the stored copy.
- R6: `s_sw_set` high at an edge leaves pending bit 1 set after that edge, even when a software write or clear to that bit happens in the same cycle.
- R7: Any bit of `ovf_flags` high at an edge leaves pending bit 13 set after that edge, even when software clears it in the same cycle.
- R8: The supervisor pending view (address 0x144) and the supervisor enable view (address 0x104) read the machine register ANDed with `deleg`. Their writes change only the bits that are delegated and writable.
- R9: The op codes are 0 for read only, 1 for write, 2 for set bits and 3 for clear bits. The pending register sits at 0x344 and the enable register at 0x304. `csr_rdata` gives the value before the update, and the update takes effect at the same edge. With `csr_en` low, or op 0, nothing is stored.
- R10: Reset clears every enable bit and every software-held pending bit.
- R11: An access to any other address reads zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_en | input | 1 | Register access this cycle |
| csr_addr | input | 12 | Register address |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | XLEN | Write data / bit operand |
| csr_rdata | output | XLEN | Pre-update contents of addressed register |
| deleg | input | XLEN | Delegation mask for the supervisor views |
| m_ext_irq | input | 1 | Machine external request line |
| m_tmr_irq | input | 1 | Machine timer request line |
| m_sw_irq | input | 1 | Machine software request line |
| s_ext_ctrl | input | 1 | Supervisor external signal from the interrupt controller |
| s_sw_set | input | 1 | Platform strobe raising supervisor software pending |
| ovf_flags | input | NOVF | Counter overflow flags |
| m_pending | output | XLEN | Current pending value as read |
| m_enable | output | XLEN | Current enable value |

## Verification
Some behaviours are checked by assertions on every cycle:
- a full write to the enable register lands masked at the next edge;
- a clear of the supervisor timer bit takes effect;
- a plain write of zero to bit 9 leaves only the controller line visible;
- the platform strobe and the overflow flags always win against software;
- writes through the supervisor enable view leave undelegated bits untouched;
- an idle cycle holds the enable register.

Other behaviours only show in the bench's sweeps. These are the exact pre-update read data across all four addresses, all op codes and delegation patterns, the OR in the bit 9 read, and the read-only machine bits. The sweeps also cover silent stray addresses and the state after reset.

// File: rtl/irq_pend_en_regs.sv
module irq_pend_en_regs #(
  parameter int XLEN = 32,
  parameter int NOVF = 4,
  parameter logic [11:0] A_MIP = 12'h344,
  parameter logic [11:0] A_MIE = 12'h304,
  parameter logic [11:0] A_SIP = 12'h144,
  parameter logic [11:0] A_SIE = 12'h104
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic [11:0]     csr_addr,
  input  logic [1:0]      csr_op,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [XLEN-1:0] deleg,
  input  logic            m_ext_irq,
  input  logic            m_tmr_irq,
  input  logic            m_sw_irq,
  input  logic            s_ext_ctrl,
  input  logic            s_sw_set,
  input  logic [NOVF-1:0] ovf_flags,
  output logic [XLEN-1:0] m_pending,
  output logic [XLEN-1:0] m_enable
);
  localparam int B_SSI = 1, B_MSI = 3, B_STI = 5, B_MTI = 7;
  localparam int B_SEI = 9, B_MEI = 11, B_OVF = 13;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3;
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  localparam logic [XLEN-1:0] SW_MASK = (ONE << B_SSI) | (ONE << B_STI) | (ONE << B_SEI) | (ONE << B_OVF);
  localparam logic [XLEN-1:0] EN_MASK = SW_MASK | (ONE << B_MSI) | (ONE << B_MTI) | (ONE << B_MEI);

  function automatic logic [XLEN-1:0] apply_op(input logic [XLEN-1:0] b, input logic [XLEN-1:0] w,
                                               input logic [1:0] op);
    case (op)
      OP_WR:   apply_op = w;
      OP_SET:  apply_op = b | w;
      OP_CLR:  apply_op = b & ~w;
      default: apply_op = b;
    endcase
  endfunction

  logic [XLEN-1:0] pend_q, en_q, pend_nx, en_nx, hw_view, hw_set;
  logic [XLEN-1:0] sp_mask, se_mask;
  logic hit_mip, hit_mie, hit_sip, hit_sie;

  assign hit_mip = csr_en && csr_addr == A_MIP;
  assign hit_mie = csr_en && csr_addr == A_MIE;
  assign hit_sip = csr_en && csr_addr == A_SIP;
  assign hit_sie = csr_en && csr_addr == A_SIE;

  assign hw_view = (XLEN'(m_sw_irq) << B_MSI) | (XLEN'(m_tmr_irq) << B_MTI) |
                   (XLEN'(m_ext_irq) << B_MEI) | (XLEN'(s_ext_ctrl) << B_SEI);
  assign hw_set  = (XLEN'(s_sw_set) << B_SSI) | (XLEN'(|ovf_flags) << B_OVF);

  assign m_pending = pend_q | hw_view;
  assign m_enable  = en_q;

  assign sp_mask = SW_MASK & deleg;
  assign se_mask = EN_MASK & deleg;

  always_comb begin
    csr_rdata = '0;
    if (hit_mip) csr_rdata = m_pending;
    if (hit_mie) csr_rdata = en_q;
    if (hit_sip) csr_rdata = m_pending & deleg;
    if (hit_sie) csr_rdata = en_q & deleg;
  end

  always_comb begin
    pend_nx = pend_q;
    en_nx   = en_q;
    if (hit_mip) pend_nx = apply_op(pend_q, csr_wdata, csr_op) & SW_MASK;
    if (hit_sip) pend_nx = (pend_q & ~sp_mask) | (apply_op(pend_q, csr_wdata, csr_op) & sp_mask);
    if (hit_mie) en_nx = apply_op(en_q, csr_wdata, csr_op) & EN_MASK;
    if (hit_sie) en_nx = (en_q & ~se_mask) | (apply_op(en_q, csr_wdata, csr_op) & se_mask);
    pend_nx = pend_nx | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_nx;
      en_q   <= en_nx;
    end
  end

  p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == A_MIE && csr_op == OP_WR) |=> m_enable == ($past(csr_wdata) & EN_MASK));

  p_sti_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == A_MIP && csr_op == OP_CLR && csr_wdata[B_STI]) |=> !m_pending[B_STI]);

  p_sei_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == A_MIP && csr_op == OP_WR && !csr_wdata[B_SEI]) |=> m_pending[B_SEI] == s_ext_ctrl);

  p_ssi_hw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_sw_set |=> m_pending[B_SSI]);

  p_ovf_hw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_flags) |=> m_pending[B_OVF]);

  p_sie_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == A_SIE) |=> (m_enable & ~$past(deleg)) == ($past(m_enable) & ~$past(deleg)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_en || csr_op == OP_RD) |=> $stable(m_enable));
endmodule

// File: tb/irq_pend_en_regs_tb_top.sv
module irq_pend_en_regs_tb_top;
  localparam int XLEN = 32;
  localparam int NOVF = 4;
  localparam logic [31:0] SWM = 32'h2222;
  localparam logic [31:0] ENM = 32'h2AAA;
  localparam logic [11:0] MIP = 12'h344, MIE = 12'h304, SIP = 12'h144, SIE = 12'h104;

  logic clk = 0, rst_n = 0;
  logic csr_en = 0;
  logic [11:0] csr_addr = '0;
  logic [1:0] csr_op = '0;
  logic [31:0] csr_wdata = '0, deleg = '0;
  logic [31:0] csr_rdata, m_pending, m_enable;
  logic m_ext_irq = 0, m_tmr_irq = 0, m_sw_irq = 0, s_ext_ctrl = 0, s_sw_set = 0;
  logic [NOVF-1:0] ovf_flags = '0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mdl_sw = '0, mdl_en = '0, lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  irq_pend_en_regs #(.XLEN(XLEN), .NOVF(NOVF)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_addr(csr_addr), .csr_op(csr_op),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .deleg(deleg), .m_ext_irq(m_ext_irq),
    .m_tmr_irq(m_tmr_irq), .m_sw_irq(m_sw_irq), .s_ext_ctrl(s_ext_ctrl), .s_sw_set(s_sw_set),
    .ovf_flags(ovf_flags), .m_pending(m_pending), .m_enable(m_enable));

  function automatic logic [31:0] view_pend();
    view_pend = mdl_sw | (32'(m_sw_irq) << 3) | (32'(m_tmr_irq) << 7) |
                (32'(m_ext_irq) << 11) | (32'(s_ext_ctrl) << 9);
  endfunction

  function automatic logic [31:0] opf(input logic [31:0] b, input logic [31:0] w, input logic [1:0] op);
    case (op)
      2'd1: opf = w;
      2'd2: opf = b | w;
      2'd3: opf = b & ~w;
      default: opf = b;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
  endtask

  task automatic do_op(input string tag, input logic en, input logic [11:0] a,
                       input logic [1:0] op, input logic [31:0] wd);
    logic [31:0] exp_rd, mk;
    csr_en = en; csr_addr = a; csr_op = op; csr_wdata = wd;
    #1;
    exp_rd = 32'h0;
    if (en) begin
      if (a == MIP) exp_rd = view_pend();
      if (a == MIE) exp_rd = mdl_en;
      if (a == SIP) exp_rd = view_pend() & deleg;
      if (a == SIE) exp_rd = mdl_en & deleg;
    end
    check(tag, csr_rdata, exp_rd);
    @(posedge clk);
    if (en) begin
      if (a == MIP) mdl_sw = opf(mdl_sw, wd, op) & SWM;
      if (a == SIP) begin mk = SWM & deleg; mdl_sw = (mdl_sw & ~mk) | (opf(mdl_sw, wd, op) & mk); end
      if (a == MIE) mdl_en = opf(mdl_en, wd, op) & ENM;
      if (a == SIE) begin mk = ENM & deleg; mdl_en = (mdl_en & ~mk) | (opf(mdl_en, wd, op) & mk); end
    end
    mdl_sw = mdl_sw | (32'(s_sw_set) << 1) | (32'(|ovf_flags) << 13);
    @(negedge clk);
    csr_en = 0;
    check(tag, m_pending, view_pend());
    check(tag, m_enable, mdl_en);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset pend", m_pending, 32'h0);
    check("R10 reset en", m_enable, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R3 enable mask
    do_op("R3 mie write all ones", 1, MIE, 2'd1, 32'hFFFF_FFFF);
    check("R3 mie mask", m_enable, 32'h2AAA);
    // R1 read-only machine bits
    m_sw_irq = 1; m_tmr_irq = 1; m_ext_irq = 1;
    do_op("R1 mip write zero", 1, MIP, 2'd1, 32'h0);
    check("R1 machine lines", m_pending, 32'h0888);
    m_sw_irq = 0; m_tmr_irq = 0; m_ext_irq = 0;
    // R2 set then clear
    do_op("R2 mip set", 1, MIP, 2'd2, 32'hFFFF_FFFF);
    check("R2 writable bits", m_pending, 32'h2222);
    do_op("R2 mip clear stip", 1, MIP, 2'd3, 32'h0020);
    check("R2 stip cleared", m_pending, 32'h2202);
    // R4 OR on read, R5 stored copy independent of line
    do_op("R5 mip write zero", 1, MIP, 2'd1, 32'h0);
    s_ext_ctrl = 1;
    do_op("R4 read seip", 1, MIP, 2'd0, 32'h0);
    check("R4 seip or", m_pending, 32'h0200);
    do_op("R5 set other bit", 1, MIP, 2'd2, 32'h0002);
    s_ext_ctrl = 0;
    do_op("R5 line not stored", 1, MIP, 2'd0, 32'h0);
    check("R5 seip after drop", m_pending, 32'h0002);
    // R6 platform set wins over clear
    s_sw_set = 1;
    do_op("R6 clear ssip with set", 1, MIP, 2'd3, 32'h0002);
    check("R6 ssip held", m_pending[1], 1);
    s_sw_set = 0;
    // R7 overflow set wins
    ovf_flags = 4'b0100;
    do_op("R7 clear ovf with flag", 1, MIP, 2'd3, 32'h2000);
    check("R7 lcofip set", m_pending[13], 1);
    ovf_flags = '0;
    // R8 supervisor view
    do_op("R8 mie zero", 1, MIE, 2'd1, 32'h0);
    deleg = 32'h0000_0222;
    do_op("R8 sie write ones", 1, SIE, 2'd1, 32'hFFFF_FFFF);
    check("R8 sie delegated only", m_enable, 32'h0222);
    do_op("R8 sip read", 1, SIP, 2'd0, 32'h0);
    // R9 idle and pre-update read
    do_op("R9 disabled write", 0, MIE, 2'd1, 32'hFFFF_FFFF);
    check("R9 no change", m_enable, 32'h0222);
    // R11 stray address
    do_op("R11 stray write", 1, 12'h345, 2'd1, 32'hFFFF_FFFF);
    check("R11 pend untouched", m_pending, view_pend());
    // R9 sweep over addresses, ops, data, delegation and lines
    for (int i = 0; i < 1500; i++) begin
      logic [11:0] a;
      next_rand();
      case (lfsr[2:0])
        3'd0, 3'd1: a = MIP;
        3'd2, 3'd3: a = MIE;
        3'd4: a = SIP;
        3'd5: a = SIE;
        default: a = 12'h300;
      endcase
      m_sw_irq = lfsr[5]; m_tmr_irq = lfsr[6]; m_ext_irq = lfsr[7];
      s_ext_ctrl = lfsr[8]; s_sw_set = lfsr[9] & lfsr[10];
      ovf_flags = lfsr[11] ? lfsr[15:12] : 4'h0;
      deleg = {lfsr[31:16], lfsr[15:0] ^ lfsr[31:16]};
      next_rand();
      do_op("R9 sweep", lfsr[31] | lfsr[30], a, lfsr[4:3], lfsr);
    end
    // R10 reset again mid-run
    rst_n = 0;
    m_sw_irq = 0; m_tmr_irq = 0; m_ext_irq = 0; s_ext_ctrl = 0; s_sw_set = 0; ovf_flags = '0;
    @(negedge clk);
    mdl_sw = '0; mdl_en = '0;
    check("R10 reset pend again", m_pending, 32'h0);
    check("R10 reset en again", m_enable, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule